// File: doc/BRIEF.md
# Peripheral Access Watchdog

This block watches every bus cycle that a host bridge issues to a set of peripheral slots. Each slot has its own timer. The timer starts when a cycle begins, and it stops when the peripheral acknowledges. A slot may be empty, or its peripheral may hang. If the programmed number of cycles passes with no acknowledge, the block ends the cycle on its own. It reports a completion toward the host with all-ones read data, so the host bus never stalls.

A timeout also sets a sticky error bit for that slot. The bit stays set until software clears it. While the bit is set, the slot can drive an interrupt if its enable is on. Because every slot has its own bit, software threads that each own a slot can check their failures independently.

The bridge uses `busy_o` to know that a cycle is still outstanding toward the peripheral. When `busy_o` drops after a timeout, any pending write is abandoned.

Top module: `access_watchdog`

## Requirements
- R1: A one-cycle `start_i` pulse on a slot raises that slot's `busy_o` at the next clock edge. A new start always restarts the slot's timer from zero.
- R2: If the peripheral asserts `ack_i` while the slot is busy, `done_o` pulses for one cycle at the next edge with `timeout_o` low, `rdata_o` takes that cycle's `rdata_i`, and `busy_o` falls.
- R3: Let the start edge be edge 0. An acknowledge sampled at edge N, where N equals `limit_i`, is still a success and not a timeout.
- R4: With no acknowledge, `done_o` and `timeout_o` pulse together exactly `limit_i` edges after the start edge. At that point `rdata_o` is all ones and `busy_o` falls, so a pending write is discarded.
- R5: An acknowledge that arrives after a timeout is ignored. It causes no second completion.
- R6: A slot that is not busy never reports a completion and never times out, however long it stays idle.
- R7: A timeout sets the slot's `err_o` in the same cycle that `timeout_o` pulses. `err_o` stays set until `err_clr_i` is asserted (write one to clear). A set and a clear in the same cycle leave the bit set.
- R8: `irq_o` of a slot is high exactly while both `err_o` and `irq_en_i` of that slot are high.
- R9: Slots are independent. A timeout on one slot changes no other slot's error bit, interrupt or completion.
- R10: A `limit_i` of zero behaves like a limit of one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| limit_i | input | CNT_W | Timeout length in clock cycles, shared by all slots |
| start_i | input | N_SLOTS | Per-slot cycle start pulse |
| ack_i | input | N_SLOTS | Per-slot peripheral acknowledge |
| rdata_i | input | N_SLOTS*DATA_W | Per-slot peripheral read data, slot 0 in the low bits |
| irq_en_i | input | N_SLOTS | Per-slot interrupt enable |
| err_clr_i | input | N_SLOTS | Per-slot error clear, write-one-to-clear |
| busy_o | output | N_SLOTS | Per-slot cycle outstanding toward the peripheral |
| done_o | output | N_SLOTS | Per-slot completion pulse toward the host |
| timeout_o | output | N_SLOTS | Per-slot marker that the completion was forced |
| rdata_o | output | N_SLOTS*DATA_W | Per-slot read data returned to the host |
| err_o | output | N_SLOTS | Per-slot sticky bus-error status |
| irq_o | output | N_SLOTS | Per-slot interrupt |

## Verification
On every cycle, the assertions check these rules: a start arms the timer, an acknowledge while busy wins over expiry, an idle slot stays quiet, the error bit sets on a timeout and holds until cleared, a forced completion always comes with the error bit, and the interrupt never rises without the error bit. Other properties need a full sequence of stimulus, so only the bench scenarios can show them. These are the exact expiry cycle at and just past the limit, the all-ones data, a late acknowledge that is ignored, the limit of zero, and two slots that overlap with different outcomes.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_OK   = 2'd1,
    CYC_TMO  = 2'd2
  } cyc_end_e;
endpackage

// File: rtl/awd_timer.sv
module awd_timer
  import awd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             busy_o,
  output cyc_end_e         end_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [EXT_W-1:0] elapsed;
  logic             expired;

  // elapsed counts the current cycle; limit 0 falls out as limit 1
  assign elapsed = {1'b0, cnt_q} + EXT_W'(1);
  assign expired = busy_q && !ack_i && (elapsed >= {1'b0, limit_i});

  always_comb begin
    end_o = CYC_NONE;
    if (busy_q && ack_i) end_o = CYC_OK;
    else if (expired)    end_o = CYC_TMO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && (ack_i || expired)) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o = busy_q;

  a_r1_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == '0));
  a_r4_busy_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && end_o != CYC_NONE && !start_i) |=> !busy_q);
endmodule

// File: rtl/awd_status.sv
module awd_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic err_o,
  output logic irq_o
);
  logic err_q;

  // set beats clear so a fresh failure is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (set_i)  err_q <= 1'b1;
    else if (clr_i)  err_q <= 1'b0;
  end

  assign err_o = err_q;
  assign irq_o = err_q & en_i;

  a_r7_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q);
  a_r7_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
  a_r7_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_q);
endmodule

// File: rtl/awd_slot.sv
module awd_slot
  import awd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              irq_en_i,
  input  logic              err_clr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              irq_o
);
  cyc_end_e          cyc_end;
  logic              done_q, tmo_q;
  logic [DATA_W-1:0] rdata_q;

  awd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ack_i   (ack_i),
    .limit_i (limit_i),
    .busy_o  (busy_o),
    .end_o   (cyc_end)
  );

  awd_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cyc_end == CYC_TMO),
    .clr_i  (err_clr_i),
    .en_i   (irq_en_i),
    .err_o  (err_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= (cyc_end != CYC_NONE);
      tmo_q  <= (cyc_end == CYC_TMO);
      if (cyc_end == CYC_OK)  rdata_q <= rdata_i;
      if (cyc_end == CYC_TMO) rdata_q <= '1;
    end
  end

  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign rdata_o   = rdata_q;

  a_r2_ack_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ack_i) |=> (done_o && !timeout_o));
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !done_o);
  a_r7_tmo_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (done_o && err_o));
endmodule

// File: rtl/access_watchdog.sv
module access_watchdog #(
  parameter int N_SLOTS = 2,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          limit_i,
  input  logic [N_SLOTS-1:0]        start_i,
  input  logic [N_SLOTS-1:0]        ack_i,
  input  logic [N_SLOTS*DATA_W-1:0] rdata_i,
  input  logic [N_SLOTS-1:0]        irq_en_i,
  input  logic [N_SLOTS-1:0]        err_clr_i,
  output logic [N_SLOTS-1:0]        busy_o,
  output logic [N_SLOTS-1:0]        done_o,
  output logic [N_SLOTS-1:0]        timeout_o,
  output logic [N_SLOTS*DATA_W-1:0] rdata_o,
  output logic [N_SLOTS-1:0]        err_o,
  output logic [N_SLOTS-1:0]        irq_o
);
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    awd_slot #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .limit_i   (limit_i),
      .start_i   (start_i[s]),
      .ack_i     (ack_i[s]),
      .rdata_i   (rdata_i[s*DATA_W +: DATA_W]),
      .irq_en_i  (irq_en_i[s]),
      .err_clr_i (err_clr_i[s]),
      .busy_o    (busy_o[s]),
      .done_o    (done_o[s]),
      .timeout_o (timeout_o[s]),
      .rdata_o   (rdata_o[s*DATA_W +: DATA_W]),
      .err_o     (err_o[s]),
      .irq_o     (irq_o[s])
    );

    a_r8_irq_needs_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[s] |-> (err_o[s] && irq_en_i[s]));
  end
endmodule

// File: tb/tb_access_watchdog.sv
module tb_access_watchdog;
  localparam int N  = 2;
  localparam int CW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] limit = 8'd5;
  logic [N-1:0]  start = '0, ack = '0, irq_en = '0, clr = '0;
  logic [N*DW-1:0] rdata_in = '0;
  logic [N-1:0]  busy, done, tmo, err, irq;
  logic [N*DW-1:0] rdata_out;

  int checks = 0, errors = 0, cyc = 0;

  typedef struct {
    bit          tmo;
    logic [DW-1:0] data;
    int          at;
    string       req;
  } exp_t;
  exp_t exp_q[N][$];

  access_watchdog #(.N_SLOTS(N), .CNT_W(CW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .limit_i(limit), .start_i(start), .ack_i(ack),
    .rdata_i(rdata_in), .irq_en_i(irq_en), .err_clr_i(clr), .busy_o(busy),
    .done_o(done), .timeout_o(tmo), .rdata_o(rdata_out), .err_o(err), .irq_o(irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pop and compare every completion
  always @(negedge clk) if (rst_n) begin
    for (int s = 0; s < N; s++) if (done[s]) begin
      if (exp_q[s].size() == 0) begin
        check(0, "R5", $sformatf("unexpected completion slot %0d", s), 1, 0);
      end else begin
        exp_t e;
        e = exp_q[s].pop_front();
        check(tmo[s] == e.tmo, e.req, "timeout flag", tmo[s], e.tmo);
        check(rdata_out[s*DW +: DW] == e.data, e.req, "read data",
              rdata_out[s*DW +: DW], e.data);
        check(cyc == e.at, e.req, "completion cycle", cyc, e.at);
      end
    end
  end

  // d < 0: never ack; otherwise ack d cycles after the start edge
  task automatic access(int s, int d, logic [DW-1:0] data, string req);
    exp_t e;
    int eff;
    eff = (limit == 0) ? 1 : int'(limit);
    @(negedge clk);
    e.tmo  = (d < 0) || (d >= eff);
    e.data = e.tmo ? '1 : data;
    e.at   = cyc + 1 + (e.tmo ? eff : d + 1);
    e.req  = req;
    exp_q[s].push_back(e);
    start[s] = 1'b1;
    @(negedge clk);
    start[s] = 1'b0;
    check(busy[s] == 1'b1, "R1", "busy after start", busy[s], 1);
    if (d >= 0) begin
      repeat (d) @(negedge clk);
      ack[s] = 1'b1;
      rdata_in[s*DW +: DW] = data;
      @(negedge clk);
      ack[s] = 1'b0;
    end
    repeat (eff + 4) @(negedge clk);
    check(busy[s] == 1'b0, "R4", "busy idle after cycle", busy[s], 0);
  endtask

  initial begin
    #20000;
    check(0, "WDOG", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && err == 0 && irq == 0, "R6", "reset state",
          {busy, done, err, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    access(0, 2, 16'hA5A5, "R2");
    access(0, 4, 16'h1234, "R3");       // ack at the last legal cycle
    access(0, -1, 16'h0000, "R4");
    check(err[0] == 1'b1, "R7", "error set after timeout", err[0], 1);
    check(irq[0] == 1'b0, "R8", "irq masked when disabled", irq[0], 0);
    access(0, 5, 16'h5555, "R5");       // ack one cycle too late
    check(err[1] == 1'b0, "R9", "other slot untouched", err[1], 0);

    irq_en[0] = 1'b1;
    @(negedge clk);
    check(irq[0] == 1'b1, "R8", "irq with error and enable", irq[0], 1);
    repeat (20) @(negedge clk);
    check(err[0] == 1'b1, "R7", "error sticky", err[0], 1);

    clr[0] = 1'b1;
    @(negedge clk);
    clr[0] = 1'b0;
    check(err[0] == 1'b0, "R7", "error cleared", err[0], 0);
    check(irq[0] == 1'b0, "R8", "irq drops with error", irq[0], 0);

    repeat (60) @(negedge clk);         // idle: monitor flags any completion
    check(err == 0, "R6", "no expiry while idle", err, 0);

    fork
      access(1, -1, 16'h0000, "R9");
      begin
        @(negedge clk);
        access(0, 1, 16'hBEEF, "R9");
      end
    join
    check(err[1] == 1'b1 && err[0] == 1'b0, "R9", "per-slot status", err, 2);
    check(irq[1] == 1'b0, "R9", "slot 1 irq disabled", irq[1], 0);

    limit = '0;
    access(0, -1, 16'h0000, "R10");
    access(0, 0, 16'h0F0F, "R10");
    check(err[0] == 1'b1, "R10", "timeout at limit zero", err[0], 1);

    repeat (5) @(negedge clk);
    for (int s = 0; s < N; s++)
      check(exp_q[s].size() == 0, "R2", "all completions seen", exp_q[s].size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule